// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch-stage state of every hardware thread in a multithreaded core front end. Each cycle it folds the control traffic arriving from downstream (per-stage block and unblock pulses, a context-switch level, redirects from the commit and decode stages, and a flag saying the reorder buffer is still being unwound) into a single state per thread. It also keeps the redirected program counter and records which outstanding instruction-cache miss each thread is waiting on. A shared retry slot remembers the single request the cache has refused.

The fetch engine tells the controller what it did for one thread in a cycle: it picked a thread whose line has arrived, issued a line request that the cache took or refused, hit a fault, or met a quiescing instruction. The cache returns tagged responses. A response that no longer belongs to a waiting thread is dropped. The controller keeps a registered stage-active flag so the core can power down fetch when no enabled thread has work.

Top module: `fetch_thread_ctl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, every thread reads Running. Each thread PC equals `RESET_PC` and each next PC equals `RESET_PC + INST_BYTES`. `stage_active`, `cache_blocked` and `miss_cancel` are all 0.
- R2: Each thread has four sticky stall flags, one per downstream stage. Stage index s is 0 for decode, 1 for rename, 2 for execute and 3 for commit, at bit `s*NT+t` of `stall_blk`/`stall_unblk`. A block pulse sets the flag and an unblock pulse clears it. The two pulses never arrive together for the same stage. A thread is stalled when `ctx_switch` is high or when any of its flags is set after this cycle's pulses.
- R3: With no redirect this cycle, a stalled thread moves to Blocked unless it is in WaitResponse. A thread that is not stalled and is in Blocked or Squashing returns to Running.
- R4: A commit redirect has top priority. The thread PC becomes `cmt_pc`, the next PC becomes `cmt_pc + INST_BYTES`, and the state becomes Squashing.
- R5: When there is no commit redirect and `rob_squashing` is set, the thread is held in Squashing. The PC is left unchanged.
- R6: A decode redirect loads `dec_pc` and enters Squashing only when the thread is not already in Squashing. Otherwise it leaves the PC untouched.
- R7: A commit or decode redirect cancels the thread's outstanding miss. `miss_cancel` pulses in the following cycle when the thread was in WaitResponse. If the thread owns the refused request, the retry is dropped and `cache_blocked` clears.
- R8: A response is accepted only when the thread was in WaitResponse, stays there this cycle, and its tag equals the outstanding request's tag. The thread then goes to Blocked if stalled, or to AccessComplete if not. Any other response leaves the state unchanged.
- R9: `fetch_op` acts only on thread `fetch_tid`. The codes are 1 select, 2 issue accepted, 3 issue refused, 4 fault and 5 quiesce. Select moves AccessComplete to Running. The other codes act only on a Running thread. Accepted moves it to WaitResponse with tag `fetch_tag`. Refused moves it to WaitRetry and sets `cache_blocked`. Both issue codes are ignored while `cache_blocked` is set. Fault moves it to TrapPending and quiesce moves it to QuiescePending.
- R10: A `retry_ok` pulse while `cache_blocked` is set clears `cache_blocked`. If the owning thread is in WaitRetry, it moves to WaitResponse with the tag of the refused request.
- R11: `stage_active` is registered. It is 1 in the cycle after any thread with `thread_en` set reaches Running, Squashing or AccessComplete, and 0 otherwise.
- R12: `thr_state` carries 4 bits per thread, with thread t at bits `[4t+3:4t]`. The codes are Running 0, Idle 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7 and QuiescePending 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_en | input | NT | Threads counted for the stage-active flag |
| ctx_switch | input | 1 | Context switch in progress; stalls every thread |
| stall_blk | input | 4*NT | Block pulses, bit s*NT+t |
| stall_unblk | input | 4*NT | Unblock pulses, bit s*NT+t |
| cmt_squash | input | NT | Commit redirect per thread |
| cmt_pc | input | NT*PC_W | Commit redirect target per thread |
| rob_squashing | input | NT | Reorder buffer still unwinding per thread |
| dec_squash | input | NT | Decode redirect per thread |
| dec_pc | input | NT*PC_W | Decode redirect target per thread |
| fetch_op | input | 3 | Fetch engine event code |
| fetch_tid | input | ID_W | Thread the event applies to |
| fetch_tag | input | TAG_W | Tag of an issued line request |
| retry_ok | input | 1 | Cache can now take the refused request |
| resp_valid | input | 1 | Cache response present |
| resp_tid | input | ID_W | Thread of the response |
| resp_tag | input | TAG_W | Tag of the response |
| thr_state | output | 4*NT | Per-thread state codes |
| thr_pc | output | NT*PC_W | Per-thread PC |
| thr_npc | output | NT*PC_W | Per-thread next PC |
| miss_cancel | output | NT | Outstanding miss cancelled by a redirect |
| cache_blocked | output | 1 | A refused request is parked |
| stage_active | output | 1 | Some enabled thread has fetch work |

## Verification
Directed sequences first drive single causes and then overlaps. The overlaps are commit and decode redirects in the same cycle, a decode redirect arriving while the reorder buffer is unwinding, a stall landing on a thread that is waiting for a line, and a response with the wrong tag followed by one with the right tag. These separate the priority order from plain state stepping. They also show whether a stale response is dropped and whether a stalled thread that gets its line parks in Blocked. A refused request followed either by a grant or by a redirect of its owner shows whether the retry slot is released. A long random phase then mixes all inputs against a behavioural model, which exposes interactions such as grants landing on threads that were stalled out of WaitRetry.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;

   localparam int STAGES = 4;
   localparam int ST_W   = 4;

   typedef enum logic [ST_W-1:0] {
      FS_RUN        = 4'd0,
      FS_IDLE       = 4'd1,
      FS_SQUASH     = 4'd2,
      FS_BLOCK      = 4'd3,
      FS_WAIT_RESP  = 4'd4,
      FS_WAIT_RETRY = 4'd5,
      FS_ACC_DONE   = 4'd6,
      FS_TRAP       = 4'd7,
      FS_QUIESCE    = 4'd8
   } thr_state_e;

   typedef enum logic [2:0] {
      OP_NONE       = 3'd0,
      OP_SELECT     = 3'd1,
      OP_ISSUE_OK   = 3'd2,
      OP_ISSUE_NACK = 3'd3,
      OP_FAULT      = 3'd4,
      OP_QUIESCE    = 3'd5
   } fetch_op_e;

   function automatic logic has_work(thr_state_e s);
      return (s == FS_RUN) || (s == FS_SQUASH) || (s == FS_ACC_DONE);
   endfunction

endpackage

// File: rtl/fetch_stall_flags.sv
module fetch_stall_flags #(
   parameter int N_STAGE = fetch_ctl_pkg::STAGES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_STAGE-1:0] blk_i,
   input  logic [N_STAGE-1:0] unblk_i,
   input  logic               ctx_i,
   output logic               stalled_o
);

   logic [N_STAGE-1:0] flag_q;
   logic [N_STAGE-1:0] flag_d;

   generate
      if (N_STAGE < 1) begin : g_bad_cfg
         $error("fetch_stall_flags: N_STAGE must be at least 1");
      end
      for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
         assign flag_d[s] = (flag_q[s] | blk_i[s]) & ~unblk_i[s];

         // R2
         stall_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(blk_i[s] && unblk_i[s]));

         // R2
         stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[s] && !unblk_i[s]) |=> flag_q[s]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign stalled_o = ctx_i | (|flag_d);

endmodule

// File: rtl/fetch_retry_slot.sv
module fetch_retry_slot #(
   parameter int NT    = 2,
   parameter int ID_W  = 1,
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [ID_W-1:0]  set_id_i,
   input  logic [TAG_W-1:0] set_tag_i,
   input  logic             retry_i,
   input  logic [NT-1:0]    drop_i,
   output logic             busy_o,
   output logic [TAG_W-1:0] tag_o,
   output logic [NT-1:0]    grant_o
);

   logic             busy_q;
   logic [ID_W-1:0]  owner_q;
   logic [TAG_W-1:0] tag_q;
   logic [NT-1:0]    drop_sel;

   generate
      for (genvar t = 0; t < NT; t++) begin : g_owner
         assign drop_sel[t] = drop_i[t] && (owner_q == ID_W'(t));
         assign grant_o[t]  = retry_i && busy_q && (owner_q == ID_W'(t));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         owner_q <= '0;
         tag_q   <= '0;
      end else if (set_i) begin
         busy_q  <= 1'b1;
         owner_q <= set_id_i;
         tag_q   <= set_tag_i;
      end else if (busy_q && (retry_i || (|drop_sel))) begin
         busy_q  <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign tag_o  = tag_q;

   // R7
   retry_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (|drop_sel)) |=> !busy_q);

   // R10
   retry_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && retry_i) |=> !busy_q);

   // R9
   single_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |-> !busy_q);

endmodule

// File: rtl/fetch_thread_fsm.sv
module fetch_thread_fsm
   import fetch_ctl_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter int              TAG_W      = 4,
   parameter int              INST_BYTES = 4,
   parameter logic [PC_W-1:0] RESET_PC   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stalled_i,
   input  logic             cmt_sq_i,
   input  logic [PC_W-1:0]  cmt_pc_i,
   input  logic             rob_sq_i,
   input  logic             dec_sq_i,
   input  logic [PC_W-1:0]  dec_pc_i,
   input  logic             op_hit_i,
   input  fetch_op_e        op_i,
   input  logic [TAG_W-1:0] op_tag_i,
   input  logic             port_busy_i,
   input  logic             grant_i,
   input  logic [TAG_W-1:0] grant_tag_i,
   input  logic             resp_hit_i,
   input  logic [TAG_W-1:0] resp_tag_i,
   output thr_state_e       state_o,
   output thr_state_e       state_nxt_o,
   output logic [PC_W-1:0]  pc_o,
   output logic [PC_W-1:0]  npc_o,
   output logic             squash_o,
   output logic             nack_o,
   output logic             cancel_o
);

   localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

   thr_state_e       state_q, s_d;
   logic [PC_W-1:0]  pc_q, pc_d, npc_q, npc_d;
   logic             ov_q, ov_d;
   logic [TAG_W-1:0] otag_q, otag_d;
   logic             cancel_q;
   logic             sq, nack;

   always_comb begin
      s_d    = state_q;
      pc_d   = pc_q;
      npc_d  = npc_q;
      ov_d   = ov_q;
      otag_d = otag_q;
      sq     = 1'b0;
      nack   = 1'b0;

      // redirects and stalls, in priority order
      if (cmt_sq_i) begin
         s_d   = FS_SQUASH;
         pc_d  = cmt_pc_i;
         npc_d = cmt_pc_i + STEP;
         sq    = 1'b1;
      end else if (rob_sq_i) begin
         s_d = FS_SQUASH;
      end else if (dec_sq_i && state_q != FS_SQUASH) begin
         s_d   = FS_SQUASH;
         pc_d  = dec_pc_i;
         npc_d = dec_pc_i + STEP;
         sq    = 1'b1;
      end else if (stalled_i && state_q != FS_WAIT_RESP) begin
         s_d = FS_BLOCK;
      end else if (state_q == FS_BLOCK || state_q == FS_SQUASH) begin
         s_d = FS_RUN;
      end

      if (s_d != FS_WAIT_RESP) ov_d = 1'b0;

      // fetch engine event
      if (op_hit_i) begin
         case (op_i)
            OP_SELECT: if (s_d == FS_ACC_DONE) s_d = FS_RUN;
            OP_ISSUE_OK: if (s_d == FS_RUN && !port_busy_i) begin
               s_d    = FS_WAIT_RESP;
               ov_d   = 1'b1;
               otag_d = op_tag_i;
            end
            OP_ISSUE_NACK: if (s_d == FS_RUN && !port_busy_i) begin
               s_d  = FS_WAIT_RETRY;
               nack = 1'b1;
            end
            OP_FAULT:   if (s_d == FS_RUN) s_d = FS_TRAP;
            OP_QUIESCE: if (s_d == FS_RUN) s_d = FS_QUIESCE;
            default: ;
         endcase
      end

      // parked request accepted by the cache
      if (grant_i && s_d == FS_WAIT_RETRY) begin
         s_d    = FS_WAIT_RESP;
         ov_d   = 1'b1;
         otag_d = grant_tag_i;
      end

      // line return
      if (resp_hit_i && state_q == FS_WAIT_RESP && s_d == FS_WAIT_RESP &&
          ov_q && resp_tag_i == otag_q) begin
         s_d  = stalled_i ? FS_BLOCK : FS_ACC_DONE;
         ov_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= FS_RUN;
         pc_q     <= RESET_PC;
         npc_q    <= RESET_PC + STEP;
         ov_q     <= 1'b0;
         otag_q   <= '0;
         cancel_q <= 1'b0;
      end else begin
         state_q  <= s_d;
         pc_q     <= pc_d;
         npc_q    <= npc_d;
         ov_q     <= ov_d;
         otag_q   <= otag_d;
         cancel_q <= sq && (state_q == FS_WAIT_RESP);
      end
   end

   assign state_o     = state_q;
   assign state_nxt_o = s_d;
   assign pc_o        = pc_q;
   assign npc_o       = npc_q;
   assign squash_o    = sq;
   assign nack_o      = nack;
   assign cancel_o    = cancel_q;

   // R4
   commit_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_sq_i |=> (state_q == FS_SQUASH) && (pc_q == $past(cmt_pc_i)) &&
                   (npc_q == $past(cmt_pc_i) + STEP));

   // R5
   rob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_sq_i && !cmt_sq_i) |=> (state_q == FS_SQUASH) && $stable(pc_q));

   // R3
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled_i && !cmt_sq_i && !rob_sq_i && !(dec_sq_i && state_q != FS_SQUASH) &&
       state_q != FS_WAIT_RESP) |=> state_q == FS_BLOCK);

   // R7
   cancel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_q |-> $past(state_q) == FS_WAIT_RESP);

   // R8
   resp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != FS_WAIT_RESP && state_q != FS_ACC_DONE) |=> state_q != FS_ACC_DONE);

endmodule

// File: rtl/fetch_thread_ctl.sv
module fetch_thread_ctl
   import fetch_ctl_pkg::*;
#(
   parameter int              NT         = 2,
   parameter int              PC_W       = 32,
   parameter int              TAG_W      = 4,
   parameter int              INST_BYTES = 4,
   parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000,
   localparam int             ID_W       = (NT > 1) ? $clog2(NT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NT-1:0]       thread_en,
   input  logic                ctx_switch,
   input  logic [STAGES*NT-1:0] stall_blk,
   input  logic [STAGES*NT-1:0] stall_unblk,
   input  logic [NT-1:0]       cmt_squash,
   input  logic [NT*PC_W-1:0]  cmt_pc,
   input  logic [NT-1:0]       rob_squashing,
   input  logic [NT-1:0]       dec_squash,
   input  logic [NT*PC_W-1:0]  dec_pc,
   input  logic [2:0]          fetch_op,
   input  logic [ID_W-1:0]     fetch_tid,
   input  logic [TAG_W-1:0]    fetch_tag,
   input  logic                retry_ok,
   input  logic                resp_valid,
   input  logic [ID_W-1:0]     resp_tid,
   input  logic [TAG_W-1:0]    resp_tag,
   output logic [ST_W*NT-1:0]  thr_state,
   output logic [NT*PC_W-1:0]  thr_pc,
   output logic [NT*PC_W-1:0]  thr_npc,
   output logic [NT-1:0]       miss_cancel,
   output logic                cache_blocked,
   output logic                stage_active
);

   generate
      if (NT < 1 || NT > 16) begin : g_bad_nt
         $error("fetch_thread_ctl: NT out of range");
      end
      if (INST_BYTES < 1) begin : g_bad_step
         $error("fetch_thread_ctl: INST_BYTES must be positive");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("fetch_thread_ctl: TAG_W must be positive");
      end
   endgenerate

   fetch_op_e        op_e;
   logic             op_valid;
   logic [NT-1:0]    squash_vec, nack_vec, grant_vec, work_vec;
   logic             port_busy;
   logic [TAG_W-1:0] park_tag;
   logic             active_q;
   thr_state_e       st_now [NT];
   thr_state_e       st_nxt [NT];

   assign op_e     = fetch_op_e'(fetch_op);
   assign op_valid = (fetch_op >= 3'd1) && (fetch_op <= 3'd5);

   generate
      for (genvar t = 0; t < NT; t++) begin : g_thr
         logic [STAGES-1:0] blk_t, unblk_t;
         logic              stalled_t;

         for (genvar s = 0; s < STAGES; s++) begin : g_map
            assign blk_t[s]   = stall_blk[s*NT + t];
            assign unblk_t[s] = stall_unblk[s*NT + t];
         end

         fetch_stall_flags #(.N_STAGE(STAGES)) u_stall (
            .clk       (clk),
            .rst_n     (rst_n),
            .blk_i     (blk_t),
            .unblk_i   (unblk_t),
            .ctx_i     (ctx_switch),
            .stalled_o (stalled_t)
         );

         fetch_thread_fsm #(
            .PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)
         ) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .stalled_i   (stalled_t),
            .cmt_sq_i    (cmt_squash[t]),
            .cmt_pc_i    (cmt_pc[t*PC_W +: PC_W]),
            .rob_sq_i    (rob_squashing[t]),
            .dec_sq_i    (dec_squash[t]),
            .dec_pc_i    (dec_pc[t*PC_W +: PC_W]),
            .op_hit_i    (op_valid && (fetch_tid == ID_W'(t))),
            .op_i        (op_e),
            .op_tag_i    (fetch_tag),
            .port_busy_i (port_busy),
            .grant_i     (grant_vec[t]),
            .grant_tag_i (park_tag),
            .resp_hit_i  (resp_valid && (resp_tid == ID_W'(t))),
            .resp_tag_i  (resp_tag),
            .state_o     (st_now[t]),
            .state_nxt_o (st_nxt[t]),
            .pc_o        (thr_pc[t*PC_W +: PC_W]),
            .npc_o       (thr_npc[t*PC_W +: PC_W]),
            .squash_o    (squash_vec[t]),
            .nack_o      (nack_vec[t]),
            .cancel_o    (miss_cancel[t])
         );

         assign thr_state[t*ST_W +: ST_W] = st_now[t];
         assign work_vec[t] = thread_en[t] && has_work(st_nxt[t]);
      end
   endgenerate

   fetch_retry_slot #(.NT(NT), .ID_W(ID_W), .TAG_W(TAG_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (|nack_vec),
      .set_id_i  (fetch_tid),
      .set_tag_i (fetch_tag),
      .retry_i   (retry_ok),
      .drop_i    (squash_vec),
      .busy_o    (port_busy),
      .tag_o     (park_tag),
      .grant_o   (grant_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= |work_vec;
   end

   assign cache_blocked = port_busy;
   assign stage_active  = active_q;

   // checker-only copy of the enables seen at the last edge
   logic [NT-1:0] en_seen_q;
   logic [NT-1:0] live_now;
   always_ff @(posedge clk) begin
      if (!rst_n) en_seen_q <= '0;
      else        en_seen_q <= thread_en;
   end
   always_comb begin
      for (int t = 0; t < NT; t++) live_now[t] = en_seen_q[t] && has_work(st_now[t]);
   end

   // R11
   stage_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_active == (|live_now));

endmodule

// File: tb/tb_fetch_thread_ctl.sv
module tb_fetch_thread_ctl;

   localparam int CLK_PERIOD = 10;
   localparam int NT    = 2;
   localparam int PC_W  = 32;
   localparam int TAG_W = 4;
   localparam int ID_W  = 1;
   localparam logic [31:0] RST_PC = 32'h0000_1000;

   // state codes (R12)
   localparam int S_RUN = 0, S_SQ = 2, S_BLK = 3, S_WRESP = 4,
                  S_WRETRY = 5, S_ACC = 6, S_TRAP = 7, S_QUI = 8;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic                rst_n;
   logic [NT-1:0]       thread_en;
   logic                ctx_switch;
   logic [4*NT-1:0]     stall_blk, stall_unblk;
   logic [NT-1:0]       cmt_squash, rob_squashing, dec_squash;
   logic [NT*PC_W-1:0]  cmt_pc, dec_pc;
   logic [2:0]          fetch_op;
   logic [ID_W-1:0]     fetch_tid;
   logic [TAG_W-1:0]    fetch_tag;
   logic                retry_ok, resp_valid;
   logic [ID_W-1:0]     resp_tid;
   logic [TAG_W-1:0]    resp_tag;
   logic [4*NT-1:0]     thr_state;
   logic [NT*PC_W-1:0]  thr_pc, thr_npc;
   logic [NT-1:0]       miss_cancel;
   logic                cache_blocked, stage_active;

   fetch_thread_ctl dut (
      .clk(clk), .rst_n(rst_n), .thread_en(thread_en), .ctx_switch(ctx_switch),
      .stall_blk(stall_blk), .stall_unblk(stall_unblk),
      .cmt_squash(cmt_squash), .cmt_pc(cmt_pc), .rob_squashing(rob_squashing),
      .dec_squash(dec_squash), .dec_pc(dec_pc),
      .fetch_op(fetch_op), .fetch_tid(fetch_tid), .fetch_tag(fetch_tag),
      .retry_ok(retry_ok), .resp_valid(resp_valid), .resp_tid(resp_tid), .resp_tag(resp_tag),
      .thr_state(thr_state), .thr_pc(thr_pc), .thr_npc(thr_npc),
      .miss_cancel(miss_cancel), .cache_blocked(cache_blocked), .stage_active(stage_active)
   );

   int    total = 0;
   int    bad = 0;
   string cur_req = "R1";
   bit    finished = 0;

   // behavioural reference state
   int          m_st   [NT];
   bit          m_flag [NT][4];
   logic [31:0] m_pc   [NT];
   bit          m_ov   [NT];
   int          m_otag [NT];
   bit          m_cancel [NT];
   bit          m_blk;
   int          m_own, m_rtag;
   bit          m_act;

   task automatic chk(string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int t = 0; t < NT; t++) begin
         m_st[t] = S_RUN; m_pc[t] = RST_PC; m_ov[t] = 0; m_otag[t] = 0; m_cancel[t] = 0;
         for (int s = 0; s < 4; s++) m_flag[t][s] = 0;
      end
      m_blk = 0; m_own = 0; m_rtag = 0; m_act = 0;
   endtask

   task automatic model_step();
      bit old_blk, set_req, drop_owner, act;
      int old_own, old_rtag;
      old_blk = m_blk; old_own = m_own; old_rtag = m_rtag;
      set_req = 0; drop_owner = 0; act = 0;
      for (int t = 0; t < NT; t++) begin
         int ns, prev, old_tag;
         bit sq, stl, old_ov;
         prev = m_st[t]; ns = prev; sq = 0; old_ov = m_ov[t]; old_tag = m_otag[t];
         stl = ctx_switch;
         for (int s = 0; s < 4; s++) begin
            if (stall_blk[s*NT+t])   m_flag[t][s] = 1;
            if (stall_unblk[s*NT+t]) m_flag[t][s] = 0;
            if (m_flag[t][s]) stl = 1;
         end
         if (cmt_squash[t]) begin
            ns = S_SQ; m_pc[t] = cmt_pc[t*PC_W +: PC_W]; sq = 1;
         end else if (rob_squashing[t]) begin
            ns = S_SQ;
         end else if (dec_squash[t] && prev != S_SQ) begin
            ns = S_SQ; m_pc[t] = dec_pc[t*PC_W +: PC_W]; sq = 1;
         end else if (stl && prev != S_WRESP) begin
            ns = S_BLK;
         end else if (prev == S_BLK || prev == S_SQ) begin
            ns = S_RUN;
         end
         if (ns != S_WRESP) m_ov[t] = 0;
         if (int'(fetch_tid) == t) begin
            case (fetch_op)
               3'd1: if (ns == S_ACC) ns = S_RUN;
               3'd2: if (ns == S_RUN && !old_blk) begin
                  ns = S_WRESP; m_ov[t] = 1; m_otag[t] = int'(fetch_tag);
               end
               3'd3: if (ns == S_RUN && !old_blk) begin
                  ns = S_WRETRY; set_req = 1;
               end
               3'd4: if (ns == S_RUN) ns = S_TRAP;
               3'd5: if (ns == S_RUN) ns = S_QUI;
               default: ;
            endcase
         end
         if (retry_ok && old_blk && old_own == t && ns == S_WRETRY) begin
            ns = S_WRESP; m_ov[t] = 1; m_otag[t] = old_rtag;
         end
         if (resp_valid && int'(resp_tid) == t && prev == S_WRESP && ns == S_WRESP &&
             old_ov && int'(resp_tag) == old_tag) begin
            ns = stl ? S_BLK : S_ACC; m_ov[t] = 0;
         end
         m_cancel[t] = sq && (prev == S_WRESP);
         if (sq && old_blk && old_own == t) drop_owner = 1;
         m_st[t] = ns;
         if (thread_en[t] && (ns == S_RUN || ns == S_SQ || ns == S_ACC)) act = 1;
      end
      if (set_req) begin
         m_blk = 1; m_own = int'(fetch_tid); m_rtag = int'(fetch_tag);
      end else if (old_blk && (retry_ok || drop_owner)) begin
         m_blk = 0;
      end
      m_act = act;
   endtask

   task automatic compare();
      for (int t = 0; t < NT; t++) begin
         chk($sformatf("state[%0d]", t), thr_state[4*t +: 4], m_st[t]);
         chk($sformatf("pc[%0d]", t), thr_pc[t*PC_W +: PC_W], m_pc[t]);
         chk($sformatf("npc[%0d]", t), thr_npc[t*PC_W +: PC_W], m_pc[t] + 32'd4);
         chk($sformatf("miss_cancel[%0d]", t), miss_cancel[t], m_cancel[t]);
      end
      chk("cache_blocked", cache_blocked, m_blk);
      chk("stage_active", stage_active, m_act);
   endtask

   task automatic clear_pulses();
      stall_blk = '0; stall_unblk = '0; cmt_squash = '0; dec_squash = '0;
      fetch_op = 3'd0; retry_ok = 0; resp_valid = 0;
   endtask

   task automatic tick();
      model_step();
      @(negedge clk);
      compare();
      clear_pulses();
   endtask

   task automatic blk(int s, int t);   stall_blk[s*NT+t] = 1;   endtask
   task automatic unblk(int s, int t); stall_unblk[s*NT+t] = 1; endtask
   task automatic op(int code, int t, int tag);
      fetch_op = 3'(code); fetch_tid = ID_W'(t); fetch_tag = TAG_W'(tag);
   endtask
   task automatic resp(int t, int tag);
      resp_valid = 1; resp_tid = ID_W'(t); resp_tag = TAG_W'(tag);
   endtask
   task automatic csq(int t, logic [31:0] a); cmt_squash[t] = 1; cmt_pc[t*PC_W +: PC_W] = a; endtask
   task automatic dsq(int t, logic [31:0] a); dec_squash[t] = 1; dec_pc[t*PC_W +: PC_W] = a; endtask

   initial begin
      rst_n = 0; thread_en = '1; ctx_switch = 0; rob_squashing = '0;
      cmt_pc = '0; dec_pc = '0; fetch_tid = '0; fetch_tag = '0; resp_tid = '0; resp_tag = '0;
      clear_pulses();
      model_reset();
      repeat (3) @(negedge clk);
      cur_req = "R1"; compare();
      rst_n = 1;
      tick();                                   // first active cycle still at reset values
      cur_req = "R11"; tick();

      // sticky stalls
      cur_req = "R2"; blk(0, 0); tick();
      chk("R2 t0 blocked", thr_state[3:0], S_BLK);
      repeat (3) tick();
      cur_req = "R3"; unblk(0, 0); tick();
      chk("R3 t0 running", thr_state[3:0], S_RUN);
      cur_req = "R2"; blk(1, 1); ctx_switch = 1; tick(); tick();
      ctx_switch = 0; tick();
      unblk(1, 1); tick(); tick();

      // issue, stall while waiting, mismatched then matched response
      cur_req = "R9"; op(2, 0, 5); tick();
      chk("R9 t0 waiting", thr_state[3:0], S_WRESP);
      cur_req = "R3"; blk(2, 0); tick();
      chk("R3 wait kept under stall", thr_state[3:0], S_WRESP);
      cur_req = "R8"; resp(0, 6); tick();
      chk("R8 stale tag ignored", thr_state[3:0], S_WRESP);
      resp(0, 5); tick();
      chk("R8 stalled line -> blocked", thr_state[3:0], S_BLK);
      unblk(2, 0); tick();
      op(2, 0, 3); tick();
      resp(0, 3); tick();
      chk("R8 line -> access complete", thr_state[3:0], S_ACC);
      cur_req = "R9"; op(1, 0, 0); tick();
      chk("R9 select -> running", thr_state[3:0], S_RUN);

      // redirect cancels outstanding miss
      cur_req = "R7"; op(2, 1, 2); tick();
      csq(1, 32'h0000_0100); tick();
      chk("R7 cancel pulse", miss_cancel[1], 1);
      chk("R4 pc redirect", thr_pc[PC_W +: PC_W], 32'h0000_0100);
      resp(1, 2); tick();
      tick();

      // refused request, port busy, grant
      cur_req = "R10"; op(3, 0, 9); tick();
      chk("R9 refused -> retry", thr_state[3:0], S_WRETRY);
      op(2, 1, 1); tick();
      chk("R9 issue ignored while blocked", thr_state[7:4], S_RUN);
      retry_ok = 1; tick();
      chk("R10 grant -> waiting", thr_state[3:0], S_WRESP);
      resp(0, 9); tick();
      op(1, 0, 0); tick();

      // redirect of the owner drops the parked request
      cur_req = "R7"; op(3, 1, 4); tick();
      dsq(1, 32'h0000_0200); tick();
      chk("R7 retry dropped", cache_blocked, 0);
      tick();

      // priority between redirect sources
      cur_req = "R4"; csq(0, 32'h0000_0300); dsq(0, 32'h0000_0400); tick();
      chk("R4 commit wins", thr_pc[31:0], 32'h0000_0300);
      cur_req = "R5"; rob_squashing[0] = 1; tick();
      cur_req = "R6"; dsq(0, 32'h0000_0500); tick();
      chk("R6 decode ignored while squashing", thr_pc[31:0], 32'h0000_0300);
      rob_squashing[0] = 0; dsq(0, 32'h0000_0600); tick();
      chk("R6 decode ignored, back to running", thr_state[3:0], S_RUN);
      dsq(0, 32'h0000_0700); tick();
      chk("R6 decode redirect", thr_pc[31:0], 32'h0000_0700);
      tick();

      // fault, quiesce and the active flag
      cur_req = "R9"; op(4, 0, 0); tick();
      op(5, 1, 0); tick();
      chk("R9 quiesce", thr_state[7:4], S_QUI);
      cur_req = "R11"; tick();
      chk("R11 idle stage", stage_active, 0);
      csq(1, 32'h0000_0800); thread_en = 2'b01; tick(); tick();
      thread_en = 2'b11; csq(0, 32'h0000_0900); tick(); tick();

      // mixed random traffic
      cur_req = "R12";
      for (int i = 0; i < 600; i++) begin
         for (int k = 0; k < 4*NT; k++) begin
            int r;
            r = int'($urandom % 14);
            if (r == 0) stall_blk[k] = 1;
            else if (r == 1) stall_unblk[k] = 1;
         end
         for (int t = 0; t < NT; t++) begin
            if ($urandom % 18 == 0) csq(t, $urandom & 32'hffff_fffc);
            if ($urandom % 9 == 0)  dsq(t, $urandom & 32'hffff_fffc);
            rob_squashing[t] = ($urandom % 12 == 0);
         end
         ctx_switch = ($urandom % 25 == 0);
         if ($urandom % 40 == 0) thread_en = NT'($urandom);
         op(int'($urandom % 8), int'($urandom % NT), int'($urandom % 4));
         if ($urandom % 3 == 0) resp(int'($urandom % NT), int'($urandom % 4));
         retry_ok = ($urandom % 5 == 0);
         tick();
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete (R1) actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule